// File: doc/BRIEF.md
# I2C-controlled octal switch register

This block is a two-wire serial slave that owns one 8-bit register, each bit of which enables one of eight switches. The serial clock and data lines come in without any relation to the system clock. They pass through synchronizers, and edge detectors then find SCL edges and the bus START and STOP events. The slave answers the 7-bit address `1 0 0 1 0 A1 A0`, where the last two bits come from static strap pins. A write loads the register after every complete data byte. A read sends the live register back.

The slave never drives SDA high. It only asserts `sda_oe`, which pulls the open-drain line low. The protocol engine is one state machine with these states:

- `ST_IDLE`: bus free.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_WR_DATA`: shifting in a data byte.
- `ST_WR_ACK`: acknowledging a data byte.
- `ST_RD_DATA`: driving the register out.
- `ST_RD_ACK`: sampling the master's acknowledge.
- `ST_WAIT`: ignoring the bus until the next START or STOP.

The transitions are these:

- START in any state goes to `ST_ADDR`.
- STOP in any state goes to `ST_IDLE`.
- From `ST_ADDR`, after 8 bits, a matching address goes to `ST_ADDR_ACK` and any other address goes to `ST_WAIT`.
- `ST_ADDR_ACK` goes to `ST_WR_DATA` when R/W=0 and to `ST_RD_DATA` when R/W=1.
- `ST_WR_DATA` goes to `ST_WR_ACK` after 8 bits, loading the register.
- `ST_WR_ACK` returns to `ST_WR_DATA`.
- `ST_RD_DATA` goes to `ST_RD_ACK` after 8 bits.
- From `ST_RD_ACK`, a master ACK goes back to `ST_RD_DATA` and a NACK goes to `ST_WAIT`.

Top module: `i2c_octal_switch`

## Requirements
- R1: After synchronous active-high reset `sw_en` is 0x00 and `sda_oe` is 0.
- R2: START means SDA falls while SCL is high. A START in any state, including a repeated START, restarts address reception.
- R3: The address byte is sent MSB first as 1,0,0,1,0,A1,A0 followed by R/W, with A1=`addr_pins[1]` and A0=`addr_pins[0]`. On a match the slave pulls SDA low during the ninth SCL pulse. On a mismatch it never pulls SDA low, and later bytes have no effect until the next START.
- R4: With R/W=0 each data byte is taken MSB first. The first bit received lands in `sw_en[7]` and the last in `sw_en[0]`. `sw_en` changes only when a full data byte has been received.
- R5: Every data byte of a write burst updates `sw_en` and is acknowledged on its ninth pulse.
- R6: With R/W=1 the slave drives the current register value MSB first after the address ACK, pulling SDA low for each 0 bit.
- R7: After a master ACK on a read, the register is sent again. After a NACK the slave releases SDA.
- R8: `sda_oe` changes only while the synchronized SCL is low.
- R9: STOP means SDA rises while SCL is high. STOP returns the slave to idle, and bytes clocked after a STOP with no START are ignored.
- R10: A START in the middle of a data byte discards the partial byte and leaves `sw_en` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock from the bus, asynchronous |
| sda_in | input | 1 | Serial data line as seen on the bus, asynchronous |
| addr_pins | input | 2 | Strapped low address bits {A1, A0} |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| sw_en | output | 8 | Switch enables, bit 7 = switch 8, bit 0 = switch 1 |

## Verification
Every cycle, the assertions check the following:

- `sda_oe` moves only while SCL is low.
- The switch register changes only at the end of a received write byte.
- A START always lands in address reception and a STOP always lands in idle.
- The bit counter stays in range.

Only the bench scenarios can show the rest:

- Acknowledge and no-acknowledge at the bus.
- The bit order of written and read bytes.
- Repeated read after a master ACK.
- Mismatched addresses and post-STOP bytes being ignored.
- A repeated START discarding a half-received byte.

// File: rtl/i2csw_pkg.sv
package i2csw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_WAIT
    } sw_state_t;
endpackage

// File: rtl/i2csw_sync.sv
module i2csw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_prev;
    logic              sda_prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= 1'b1;
                    sda_q <= 1'b1;
                end else begin
                    scl_q <= scl_in;
                    sda_q <= sda_in;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q <= '1;
                    sda_q <= '1;
                end else begin
                    scl_q <= {scl_q[STAGES-2:0], scl_in};
                    sda_q <= {sda_q[STAGES-2:0], sda_in};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = ~scl_prev & scl_s;
    assign scl_fall  = scl_prev & ~scl_s;
    assign start_det = scl_prev & scl_s & sda_prev & ~sda_s;
    assign stop_det  = scl_prev & scl_s & ~sda_prev & sda_s;
endmodule

// File: rtl/i2csw_fsm.sv
module i2csw_fsm
    import i2csw_pkg::*;
#(
    parameter int         DW     = 8,
    parameter int         PW     = 2,
    parameter logic [4:0] PREFIX = 5'b10010
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_s,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic [PW-1:0] addr_pins,
    output logic          sda_oe,
    output logic [DW-1:0] sw_reg
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] FULL = CW'(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    sw_state_t     state;
    logic [CW-1:0] cnt;
    logic [DW-1:0] rx;
    logic [DW-1:0] tx;
    logic          rw;
    logic          mack;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            rx     <= '0;
            tx     <= '0;
            sw_reg <= '0;
            rw     <= 1'b0;
            mack   <= 1'b1;
        end else if (start_det) begin
            state <= ST_ADDR;
            cnt   <= '0;
        end else if (stop_det) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE, ST_WAIT: ;
                ST_ADDR: begin
                    if (scl_rise) begin
                        rx  <= {rx[DW-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall && cnt == FULL) begin
                        cnt <= '0;
                        if (rx[DW-1:1] == {PREFIX, addr_pins}) begin
                            rw    <= rx[0];
                            state <= ST_ADDR_ACK;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw) begin
                            tx    <= sw_reg;
                            state <= ST_RD_DATA;
                        end else begin
                            state <= ST_WR_DATA;
                        end
                    end
                end
                ST_WR_DATA: begin
                    if (scl_rise) begin
                        rx  <= {rx[DW-2:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end else if (scl_fall && cnt == FULL) begin
                        sw_reg <= rx;
                        cnt    <= '0;
                        state  <= ST_WR_ACK;
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        cnt   <= '0;
                        state <= ST_WR_DATA;
                    end
                end
                ST_RD_DATA: begin
                    if (scl_fall) begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            state <= ST_RD_ACK;
                        end else begin
                            tx  <= {tx[DW-2:0], 1'b0};
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        mack <= sda_s;
                    end else if (scl_fall) begin
                        if (!mack) begin
                            tx    <= sw_reg;
                            state <= ST_RD_DATA;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_DATA:             sda_oe = ~tx[DW-1];
            default:                sda_oe = 1'b0;
        endcase
    end

    assert_oe_scl_low_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);

    assert_sw_byte_end_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(sw_reg) |-> ($past(state) == ST_WR_DATA && $past(scl_fall)));

    assert_start_addr_R2: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (state == ST_ADDR));

    assert_stop_idle_R9: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> (state == ST_IDLE));

    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);
endmodule

// File: rtl/i2c_octal_switch.sv
module i2c_octal_switch #(
    parameter int SYNC_STAGES = 2,
    parameter int DW          = 8,
    parameter int PW          = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_in,
    input  logic          sda_in,
    input  logic [PW-1:0] addr_pins,
    output logic          sda_oe,
    output logic [DW-1:0] sw_en
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2csw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2csw_fsm #(.DW(DW), .PW(PW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .addr_pins (addr_pins),
        .sda_oe    (sda_oe),
        .sw_reg    (sw_en)
    );

    assert_stop_release_R9: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_oe);
endmodule

// File: tb/i2c_octal_switch_test.sv
`timescale 1ns/1ps
module i2c_octal_switch_test;
    localparam int H = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [1:0] pins = 2'b01;
    logic       sda_oe;
    logic [7:0] sw_en;
    logic       sda_line;
    int         errors = 0;
    int         checks = 0;
    bit         done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_octal_switch uut (
        .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
        .addr_pins(pins), .sda_oe(sda_oe), .sw_en(sw_en)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wt(H / 2);
        scl = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl = 1'b0; wt(H / 2);
    endtask

    task automatic bus_stop;
        scl = 1'b0; sda_m = 1'b0; wt(H);
        scl = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic bit_xfer(input logic b, output logic seen);
        scl = 1'b0; wt(H / 2);
        sda_m = b; wt(H / 2);
        scl = 1'b1; wt(H / 2);
        seen = sda_line; wt(H / 2);
        scl = 1'b0;
    endtask

    task automatic put_byte(input logic [7:0] d, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(d[i], s);
        bit_xfer(1'b1, s);
        acked = ~s;
    endtask

    task automatic put_bits(input logic [7:0] d, input int n);
        logic s;
        for (int i = 7; i > 7 - n; i--) bit_xfer(d[i], s);
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, s);
            d[i] = s;
        end
        bit_xfer(mack, s);
    endtask

    function automatic logic [7:0] adr(input logic [1:0] p, input logic rw);
        return {5'b10010, p, rw};
    endfunction

    task automatic t_reset;
        check("R1 sw_en", sw_en, 8'h00);
        check("R1 sda_oe", {7'd0, sda_oe}, 8'h00);
    endtask

    task automatic t_write;
        logic a;
        bus_start;
        put_byte(adr(2'b01, 1'b0), a);
        check("R3 addr ack", {7'd0, a}, 8'h01);
        put_byte(8'hA5, a);
        check("R5 data ack", {7'd0, a}, 8'h01);
        check("R4 write A5", sw_en, 8'hA5);
        bus_stop;
        check("R9 release after stop", {7'd0, sda_oe}, 8'h00);
    endtask

    task automatic t_burst;
        logic a;
        bus_start;
        put_byte(adr(2'b01, 1'b0), a);
        put_byte(8'h01, a);
        check("R4 lsb to sw_en[0]", sw_en, 8'h01);
        put_byte(8'h3C, a);
        check("R5 burst ack", {7'd0, a}, 8'h01);
        check("R5 burst 3C", sw_en, 8'h3C);
        put_byte(8'hFE, a);
        check("R5 burst FE", sw_en, 8'hFE);
        bus_stop;
    endtask

    task automatic t_read;
        logic a;
        logic [7:0] d;
        bus_start;
        put_byte(adr(2'b01, 1'b1), a);
        check("R6 read addr ack", {7'd0, a}, 8'h01);
        get_byte(1'b0, d);
        check("R6 read value", d, 8'hFE);
        get_byte(1'b1, d);
        check("R7 repeat after ack", d, 8'hFE);
        wt(H);
        check("R7 release after nack", {7'd0, sda_oe}, 8'h00);
        bus_stop;
    endtask

    task automatic t_mismatch;
        logic a;
        bus_start;
        put_byte(adr(2'b10, 1'b0), a);
        check("R3 wrong pins nack", {7'd0, a}, 8'h00);
        put_byte(8'h55, a);
        check("R3 ignored data nack", {7'd0, a}, 8'h00);
        check("R3 ignored data", sw_en, 8'hFE);
        bus_stop;
        bus_start;
        put_byte({5'b10011, 2'b01, 1'b0}, a);
        check("R3 wrong prefix nack", {7'd0, a}, 8'h00);
        bus_stop;
    endtask

    task automatic t_after_stop;
        logic a;
        put_byte(adr(2'b01, 1'b0), a);
        put_byte(8'h11, a);
        check("R9 no ack without start", {7'd0, a}, 8'h00);
        check("R9 sw_en held", sw_en, 8'hFE);
        sda_m = 1'b1; scl = 1'b1; wt(H);
    endtask

    task automatic t_restart;
        logic a;
        logic [7:0] d;
        bus_start;
        put_byte(adr(2'b01, 1'b0), a);
        put_bits(8'h0F, 4);
        bus_start;
        check("R10 partial byte dropped", sw_en, 8'hFE);
        put_byte(adr(2'b01, 1'b1), a);
        check("R2 restart addr ack", {7'd0, a}, 8'h01);
        get_byte(1'b1, d);
        check("R2 read after restart", d, 8'hFE);
        bus_stop;
    endtask

    task automatic t_pins;
        logic a;
        pins = 2'b10; wt(H);
        bus_start;
        put_byte(adr(2'b10, 1'b0), a);
        check("R3 new pins ack", {7'd0, a}, 8'h01);
        put_byte(8'h80, a);
        check("R4 msb to sw_en[7]", sw_en, 8'h80);
        bus_stop;
    endtask

    initial begin
        wt(10);
        rst = 1'b0;
        wt(10);
        t_reset;
        t_write;
        t_burst;
        t_read;
        t_mismatch;
        t_after_stop;
        t_restart;
        t_pins;
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 150000 && !done; i++) @(negedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule